// File: doc/BRIEF.md
# Triple Time Redundant Register Stage

This block is one register stage of a pipeline that is hardened against single event transients by repeating the sampling in time instead of copying the logic. A single copy of the upstream combinational logic drives `data_i`. Three registers capture that one signal, each on its own clock phase. The phases are copies of the system clock, and each one is delayed from the previous one by a fixed spacing. A bitwise two-of-three vote of the three registers drives `data_o` into the next combinational stage. The same stage is placed on primary inputs to harden the input register.

The spacing between phases must be larger than the flip-flop setup plus hold time plus the widest transient expected, which is a few nanoseconds in all. A transient shorter than the spacing can therefore corrupt at most one of the three captures, and the vote masks it. A transient wider than the spacing can reach two captures, and the vote then passes the wrong value.

Each phase has its own asynchronous reset and its own scan enable, so a transient on one of these nets affects only one copy. When its scan enable is high, each phase register becomes an independent serial scan chain. The chains let a tester find permanent faults that the vote would otherwise hide. `disagree_o` flags any bit on which the three captures differ.

Top module: `ttr_stage`

## Requirements
- R1: When its scan enable is low, each phase register loads `data_i` on the rising edge of its own clock (index 0 = phase A, 1 = phase B, 2 = phase C).
- R2: While all three resets are low, `data_o` equals RESET_VAL (default all zeros) and `disagree_o` is 0.
- R3: `data_o` is the bitwise majority of the three phase registers. If a glitch corrupts `data_i` at only one phase edge, `data_o` after the phase C edge equals the glitch-free input.
- R4: `disagree_o` is 1 exactly when the three phase registers are not all equal.
- R5: After `data_i` changes, `data_o` still shows the previous value once only the phase A edge has passed. It shows the new value once the phase B edge has passed.
- R6: When a phase's scan enable is high, its register shifts toward the most significant bit on that phase's edge. Bit p of `scan_in_i` enters bit 0, and bit p of `scan_out_o` is the register's most significant bit (p = 0, 1, 2 for phases A, B, C).
- R7: A transient on `data_i` that covers both the A and B edges, or both the B and C edges, is captured twice. `data_o` then shows the corrupted value and `disagree_o` is 1.
- R8: Pulling only one phase's reset low forces that register to RESET_VAL, while `data_o` keeps the value the other two registers agree on.
- R9: Raising only one phase's scan enable does not change `data_o`. `data_o` still follows `data_i` through the other two phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Phase A clock |
| clk_b_i | input | 1 | Phase B clock, delayed from phase A |
| clk_c_i | input | 1 | Phase C clock, delayed from phase B |
| rst_a_ni | input | 1 | Phase A asynchronous reset, active low |
| rst_b_ni | input | 1 | Phase B asynchronous reset, active low |
| rst_c_ni | input | 1 | Phase C asynchronous reset, active low |
| scan_en_a_i | input | 1 | Phase A scan shift enable |
| scan_en_b_i | input | 1 | Phase B scan shift enable |
| scan_en_c_i | input | 1 | Phase C scan shift enable |
| scan_in_i | input | 3 | Serial scan input, one bit per phase |
| data_i | input | WIDTH | Output of the single combinational copy |
| data_o | output | WIDTH | Voted value for the next stage |
| disagree_o | output | 1 | Phase registers differ on at least one bit |
| scan_out_o | output | 3 | Serial scan output, one bit per phase |

## Verification
The capture and shift properties assume that `data_i`, `scan_in_i` and each scan enable are steady at every edge of the clock that samples them. Injected glitches are therefore timed to begin 0.2 ns before a chosen phase edge and end 0.2 ns after it, never exactly on it. Resets and enables change only at a fixed offset after the phase C edge. The voter properties assume nothing about the inputs. For that reason the bench mixes random values and random glitch masks freely, and covers single-phase, adjacent two-phase and all-phase corruption.

// File: rtl/ttr_pkg.sv
`timescale 1ns/1ps
package ttr_pkg;
  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned PH_A = 0;
  localparam int unsigned PH_B = 1;
  localparam int unsigned PH_C = 2;
endpackage

// File: rtl/ttr_phase_reg.sv
`timescale 1ns/1ps
module ttr_phase_reg #(
  parameter int unsigned     WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic             scan_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             so_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH:0]   shift_w;
  logic [WIDTH-1:0] next_w;

  assign shift_w = {q_q, scan_i};
  assign next_w  = scan_en_i ? shift_w[WIDTH-1:0] : d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RESET_VAL;
    else         q_q <= next_w;
  end

  assign q_o  = q_q;
  assign so_o = shift_w[WIDTH];

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> q_o == $past(d_i));

  p_scan_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(scan_i)}));

  p_scan_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> so_o == $past(q_o[WIDTH-2]));
endmodule

// File: rtl/ttr_majority.sv
`timescale 1ns/1ps
module ttr_majority #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] y_o,
  output logic             disagree_o
);
  always_comb begin
    y_o        = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
    disagree_o = |((a_i ^ b_i) | (a_i ^ c_i));

    // any agreeing pair must win its bit
    a_mask_r3: assert ((((a_i ~^ b_i) & (y_o ^ a_i)) |
                        ((b_i ~^ c_i) & (y_o ^ b_i)) |
                        ((a_i ~^ c_i) & (y_o ^ c_i))) == '0);
    a_flag_set_r4: assert (!disagree_o || (y_o != a_i) || (y_o != b_i) || (y_o != c_i));
    a_flag_clear_r4: assert (disagree_o || ((y_o == a_i) && (y_o == b_i) && (y_o == c_i)));
  end
endmodule

// File: rtl/ttr_stage.sv
`timescale 1ns/1ps
module ttr_stage
  import ttr_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             clk_c_i,
  input  logic             rst_a_ni,
  input  logic             rst_b_ni,
  input  logic             rst_c_ni,
  input  logic             scan_en_a_i,
  input  logic             scan_en_b_i,
  input  logic             scan_en_c_i,
  input  logic [2:0]       scan_in_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             disagree_o,
  output logic [2:0]       scan_out_o
);
  logic [NUM_PHASES-1:0] clk_w;
  logic [NUM_PHASES-1:0] rst_n_w;
  logic [NUM_PHASES-1:0] scan_en_w;
  logic [NUM_PHASES-1:0] so_w;
  logic [WIDTH-1:0]      q_w [NUM_PHASES];

  assign clk_w     = {clk_c_i, clk_b_i, clk_a_i};
  assign rst_n_w   = {rst_c_ni, rst_b_ni, rst_a_ni};
  assign scan_en_w = {scan_en_c_i, scan_en_b_i, scan_en_a_i};

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    ttr_phase_reg #(
      .WIDTH    (WIDTH),
      .RESET_VAL(RESET_VAL)
    ) u_reg (
      .clk_i    (clk_w[p]),
      .rst_ni   (rst_n_w[p]),
      .scan_en_i(scan_en_w[p]),
      .scan_i   (scan_in_i[p]),
      .d_i      (data_i),
      .q_o      (q_w[p]),
      .so_o     (so_w[p])
    );
  end

  ttr_majority #(.WIDTH(WIDTH)) u_vote (
    .a_i       (q_w[PH_A]),
    .b_i       (q_w[PH_B]),
    .c_i       (q_w[PH_C]),
    .y_o       (data_o),
    .disagree_o(disagree_o)
  );

  assign scan_out_o = so_w;
endmodule

// File: tb/tb_ttr_stage.sv
`timescale 1ns/1ps
module tb_ttr_stage;
  localparam int unsigned W = 8;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic clk_c = 1'b0;
  logic rst_a_ni, rst_b_ni, rst_c_ni;
  logic scan_en_a, scan_en_b, scan_en_c;
  logic [2:0]   scan_in;
  logic [W-1:0] data_in;
  logic [W-1:0] data_out;
  logic         disagree;
  logic [2:0]   scan_out;

  int checks = 0;
  int fails  = 0;

  // 200 MHz, phases spaced 1 ns
  initial forever #2.5 clk_a = ~clk_a;
  initial begin #1.0; forever #2.5 clk_b = ~clk_b; end
  initial begin #2.0; forever #2.5 clk_c = ~clk_c; end

  ttr_stage #(.WIDTH(W), .RESET_VAL('0)) dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .clk_c_i(clk_c),
    .rst_a_ni(rst_a_ni), .rst_b_ni(rst_b_ni), .rst_c_ni(rst_c_ni),
    .scan_en_a_i(scan_en_a), .scan_en_b_i(scan_en_b), .scan_en_c_i(scan_en_c),
    .scan_in_i(scan_in), .data_i(data_in),
    .data_o(data_out), .disagree_o(disagree), .scan_out_o(scan_out)
  );

  function automatic logic [W-1:0] maj3(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // d before and after; g during the edges flagged in hit (bit0=A,1=B,2=C)
  task automatic drive_cycle(input logic [W-1:0] d, input logic [W-1:0] g,
                             input logic [2:0] hit, input string req);
    logic [W-1:0] sa, sb, sc;
    @(posedge clk_c); #0.5 data_in = d;
    #2.3 data_in = hit[0] ? g : d;
    #0.4 data_in = (hit[0] && hit[1]) ? g : d;
    #0.6 data_in = hit[1] ? g : d;
    #0.4 data_in = (hit[1] && hit[2]) ? g : d;
    #0.6 data_in = hit[2] ? g : d;
    #0.4 data_in = d;
    #0.1;
    sa = hit[0] ? g : d;
    sb = hit[1] ? g : d;
    sc = hit[2] ? g : d;
    check(req, data_out, maj3(sa, sb, sc));
    check("R4", {{(W-1){1'b0}}, disagree}, {{(W-1){1'b0}}, (sa != sb) || (sb != sc)});
  endtask

  initial begin : watchdog
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] d, e, p, g, flip, pa, pb, pc, sh;
    void'($urandom(32'd20240611));
    rst_a_ni = 1'b0; rst_b_ni = 1'b0; rst_c_ni = 1'b0;
    scan_en_a = 1'b0; scan_en_b = 1'b0; scan_en_c = 1'b0;
    scan_in = '0; data_in = 8'h5a;

    // R2: reset state while data_i is nonzero
    #12.2;
    check("R2", data_out, '0);
    check("R2", {{(W-1){1'b0}}, disagree}, '0);
    #8.0 rst_a_ni = 1'b1; rst_b_ni = 1'b1; rst_c_ni = 1'b1;

    // R1/R3: clean captures
    drive_cycle(8'h3c, 8'h3c, 3'b000, "R1");
    drive_cycle(8'hff, 8'hff, 3'b000, "R1");
    drive_cycle(8'h00, 8'h00, 3'b000, "R3");

    // R5: new value appears after the B edge
    p = 8'h0f; d = 8'hf0;
    drive_cycle(p, p, 3'b000, "R1");
    @(posedge clk_c); #0.5 data_in = d;
    @(posedge clk_a); #0.2 check("R5", data_out, p);
    check("R4", {{(W-1){1'b0}}, disagree}, 8'h01);
    @(posedge clk_b); #0.2 check("R5", data_out, d);
    @(posedge clk_c); #0.2 check("R5", data_out, d);
    check("R4", {{(W-1){1'b0}}, disagree}, '0);

    // R3: single-phase glitches, full inversion on each phase
    drive_cycle(8'ha5, 8'h5a, 3'b001, "R3");
    drive_cycle(8'ha5, 8'h5a, 3'b010, "R3");
    drive_cycle(8'ha5, 8'h5a, 3'b100, "R3");

    // R7: transients spanning two adjacent edges
    drive_cycle(8'h12, 8'hed, 3'b011, "R7");
    drive_cycle(8'h34, 8'hcb, 3'b110, "R7");

    // R8: one reset alone is outvoted
    d = 8'h96;
    drive_cycle(d, d, 3'b000, "R1");
    @(posedge clk_c); #0.5 rst_b_ni = 1'b0;
    #0.5 check("R8", data_out, d);
    check("R8", {{(W-1){1'b0}}, disagree}, 8'h01);
    @(posedge clk_c); #0.3 check("R8", data_out, d);
    #0.2 rst_b_ni = 1'b1;
    drive_cycle(d, d, 3'b000, "R8");

    // R9: one scan enable alone is outvoted
    d = 8'h81; e = 8'h7e;
    drive_cycle(d, d, 3'b000, "R1");
    @(posedge clk_c); #0.5 scan_en_a = 1'b1; scan_in = 3'b001; data_in = e;
    @(posedge clk_c); #0.3;
    sh = {d[W-2:0], 1'b1};
    check("R9", data_out, e);
    check("R4", {{(W-1){1'b0}}, disagree}, {{(W-1){1'b0}}, sh != e});
    #0.2 scan_en_a = 1'b0; scan_in = '0;
    drive_cycle(e, e, 3'b000, "R9");

    // R6: three independent chains, vote on loaded patterns
    pa = 8'hc3; pb = 8'hc5; pc = 8'h29;
    @(posedge clk_c); #0.5 scan_en_a = 1'b1; scan_en_b = 1'b1; scan_en_c = 1'b1;
    for (int i = 0; i < W; i++) begin
      scan_in = {pc[W-1-i], pb[W-1-i], pa[W-1-i]};
      @(posedge clk_c); #0.5;
    end
    check("R6", data_out, maj3(pa, pb, pc));
    check("R6", {5'b0, scan_out}, {5'b0, pc[W-1], pb[W-1], pa[W-1]});
    check("R4", {{(W-1){1'b0}}, disagree}, 8'h01);
    // one more shift exposes bit W-2
    scan_in = 3'b000;
    @(posedge clk_c); #0.5;
    check("R6", {5'b0, scan_out}, {5'b0, pc[W-2], pb[W-2], pa[W-2]});
    check("R6", data_out, maj3({pa[W-2:0], 1'b0}, {pb[W-2:0], 1'b0}, {pc[W-2:0], 1'b0}));
    scan_en_a = 1'b0; scan_en_b = 1'b0; scan_en_c = 1'b0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      int kind;
      logic [2:0] hit;
      d = W'($urandom);
      flip = W'($urandom);
      if (flip == '0) flip = 8'h01;
      g = d ^ flip;
      kind = int'($urandom % 5);
      case (kind)
        0: hit = 3'b000;
        1: hit = 3'b001 << ($urandom % 3);
        2: hit = 3'b011;
        3: hit = 3'b110;
        default: hit = 3'b111;
      endcase
      if (hit == 3'b011 || hit == 3'b110 || hit == 3'b111)
        drive_cycle(d, g, hit, "R7");
      else
        drive_cycle(d, g, hit, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule